// File: doc/BRIEF.md
# UART baud and clock generator

This block produces the bit-rate timing for a serial transceiver. A twelve-bit divisor sets a prescaler that emits a tick once every divisor+1 system clocks. A short counter chain then divides that tick to form the transmit bit rate. In asynchronous operation the receive base enable is the raw prescaler tick, which the receiver uses for oversampling. A double-speed control removes the last divide stage, so the transmit rate doubles.

In synchronous operation the transmitter and receiver share one bit clock. In master mode that clock comes from the first divide stage and is also driven onto the external clock pin. In slave mode it is taken from the external clock pin, which passes through a two-flop synchronizer and an edge detector. A polarity input selects which edge of the synchronous clock produces the tick.

All outputs are single-cycle enables in the system clock domain. A slave clock must run slower than a quarter of the system clock.

Top module: `baud_clkgen`

## Requirements
- R1: While rst_ni is low, tx_tick_o, rx_tick_o and ext_clk_o are all 0. After reset the divisor is 0, so in asynchronous mode rx_tick_o pulses on every cycle.
- R2: In asynchronous mode (sync_mode_i=0), rx_tick_o is a one-cycle pulse that repeats every divisor+1 system clocks.
- R3: In asynchronous mode with dbl_speed_i=0, tx_tick_o repeats every 16*(divisor+1) clocks.
- R4: In asynchronous mode with dbl_speed_i=1, tx_tick_o repeats every 8*(divisor+1) clocks.
- R5: A cycle with div_wr_i=1 stores div_i and reloads the prescaler and divide chain at once. No rx_tick_o appears in the following cycle. For a written divisor d, the first rx_tick_o comes d+1 clocks after the write edge and the first tx_tick_o (normal speed) comes 16*(d+1) clocks after it.
- R6: In master mode (sync_mode_i=1, pin_out_i=1), ext_clk_o is a square wave with period 2*(divisor+1). tx_tick_o and rx_tick_o pulse once per period. dbl_speed_i has no effect in this mode.
- R7: In master mode with edge_sel_i=0, the tick appears in the first cycle in which ext_clk_o is 1. With edge_sel_i=1, it appears in the first cycle in which ext_clk_o is 0.
- R8: In slave mode (sync_mode_i=1, pin_out_i=0), a rising edge of ext_clk_i (edge_sel_i=0) or a falling edge (edge_sel_i=1) produces one tick. The tick is visible in the third clock cycle after the input changes, and the opposite edge produces no tick.
- R9: ext_clk_o stays 0 except in master mode.
- R10: tx_tick_o is never high on two consecutive cycles. Every tx_tick_o coincides with an rx_tick_o. In synchronous mode, rx_tick_o equals tx_tick_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 12 | Baud divisor value |
| div_wr_i | input | 1 | Stores div_i and reloads the counters |
| sync_mode_i | input | 1 | 1 selects synchronous operation |
| dbl_speed_i | input | 1 | Doubles the asynchronous transmit rate |
| pin_out_i | input | 1 | In synchronous mode: 1 selects master, 0 selects slave |
| edge_sel_i | input | 1 | 0 ticks on the rising clock edge, 1 on the falling edge |
| ext_clk_i | input | 1 | External clock pin input |
| tx_tick_o | output | 1 | Transmit bit enable |
| rx_tick_o | output | 1 | Receive base enable |
| ext_clk_o | output | 1 | Clock driven to the pin in master mode |

## Verification
The assertions check several properties on every cycle: transmit pulses are single-cycle and always paired with a receive pulse, the two enables match in synchronous mode, the pin output is idle outside master mode, a divisor write suppresses the next receive tick, and a master tick lines up with the selected edge of ext_clk_o. Only the bench scenarios can show the actual tick periods for each mode and divisor, the delays after a reload, and the three-cycle slave latency with its polarity choice. These depend on counting many cycles against values derived from the divisor.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    SRC_ASYNC  = 2'd0,
    SRC_MASTER = 2'd1,
    SRC_SLAVE  = 2'd2
  } clk_src_e;

  function automatic clk_src_e decode_src(input logic sync_mode, input logic pin_out);
    if (!sync_mode) return SRC_ASYNC;
    return pin_out ? SRC_MASTER : SRC_SLAVE;
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             wr_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (wr_i) begin
      div_q <= div_i;
      cnt_q <= div_i;
    end else if (cnt_q == '0) begin
      cnt_q <= div_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // a write cycle never ticks: the reload starts a fresh period
  assign tick_o = !wr_i && (cnt_q == '0);
endmodule

// File: rtl/baud_divchain.sv
module baud_divchain #(
  parameter int unsigned S1_W = 1,
  parameter int unsigned S2_W = 2,
  parameter int unsigned S3_W = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic dbl_i,
  output logic async_tx_o,
  output logic half_o,
  output logic half_rise_o,
  output logic half_fall_o
);
  localparam int unsigned DW      = S1_W + S2_W + S3_W;
  localparam int unsigned FAST_W  = S1_W + S2_W;
  localparam int unsigned RISE_AT = (1 << (S1_W - 1)) - 1;

  logic [DW-1:0] dv_q;
  logic          full_wrap, fast_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dv_q <= '0;
    else if (clr_i)  dv_q <= '0;
    else if (tick_i) dv_q <= dv_q + 1'b1;
  end

  assign full_wrap   = &dv_q;
  assign fast_wrap   = &dv_q[FAST_W-1:0];
  // double speed skips the last stage
  assign async_tx_o  = tick_i && (dbl_i ? fast_wrap : full_wrap);
  assign half_o      = dv_q[S1_W-1];
  assign half_rise_o = tick_i && (dv_q[S1_W-1:0] == RISE_AT[S1_W-1:0]);
  assign half_fall_o = tick_i && (&dv_q[S1_W-1:0]);
endmodule

// File: rtl/baud_ext_sync.sv
module baud_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], ext_i};
  end

  assign rise_o = sh_q[STAGES-1] && !sh_q[STAGES];
  assign fall_o = !sh_q[STAGES-1] && sh_q[STAGES];
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             div_wr_i,
  input  logic             sync_mode_i,
  input  logic             dbl_speed_i,
  input  logic             pin_out_i,
  input  logic             edge_sel_i,
  input  logic             ext_clk_i,
  output logic             tx_tick_o,
  output logic             rx_tick_o,
  output logic             ext_clk_o
);
  clk_src_e src, src_q;
  logic pre_tick, async_tx, half, half_rise, half_fall;
  logic ext_rise, ext_fall, sync_evt;
  logic tx_q, rx_q;

  assign src = decode_src(sync_mode_i, pin_out_i);

  baud_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (div_i),
    .wr_i  (div_wr_i),
    .tick_o(pre_tick)
  );

  baud_divchain u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (pre_tick),
    .clr_i      (div_wr_i),
    .dbl_i      (dbl_speed_i && (src == SRC_ASYNC)),
    .async_tx_o (async_tx),
    .half_o     (half),
    .half_rise_o(half_rise),
    .half_fall_o(half_fall)
  );

  baud_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ext_i (ext_clk_i),
    .rise_o(ext_rise),
    .fall_o(ext_fall)
  );

  always_comb begin
    unique case (src)
      SRC_MASTER: sync_evt = edge_sel_i ? half_fall : half_rise;
      SRC_SLAVE:  sync_evt = edge_sel_i ? ext_fall : ext_rise;
      default:    sync_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= 1'b0;
      rx_q  <= 1'b0;
      src_q <= SRC_ASYNC;
    end else begin
      src_q <= src;
      tx_q  <= (src == SRC_ASYNC) ? async_tx : sync_evt;
      rx_q  <= (src == SRC_ASYNC) ? pre_tick : sync_evt;
    end
  end

  assign tx_tick_o = tx_q;
  assign rx_tick_o = rx_q;
  assign ext_clk_o = (src_q == SRC_MASTER) && half;
endmodule

// File: rtl/baud_clkgen_chk.sv
module baud_clkgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic div_wr_i,
  input logic sync_mode_i,
  input logic pin_out_i,
  input logic edge_sel_i,
  input logic tx_tick_o,
  input logic rx_tick_o,
  input logic ext_clk_o
);
  logic mst_pos;
  assign mst_pos = sync_mode_i && pin_out_i && !edge_sel_i;

  AST_TX_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tick_o |=> !tx_tick_o); // R10
  AST_TX_WITH_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tick_o |-> rx_tick_o); // R10
  AST_SYNC_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sync_mode_i) |-> (rx_tick_o == tx_tick_o)); // R10
  AST_PIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_mode_i && pin_out_i) |=> !ext_clk_o); // R9
  AST_RELOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_wr_i && !sync_mode_i) |=> !rx_tick_o); // R5
  AST_MASTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mst_pos) && $past(mst_pos, 2) && tx_tick_o) |-> (ext_clk_o && !$past(ext_clk_o))); // R7
endmodule

bind baud_clkgen baud_clkgen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .div_wr_i   (div_wr_i),
  .sync_mode_i(sync_mode_i),
  .pin_out_i  (pin_out_i),
  .edge_sel_i (edge_sel_i),
  .tx_tick_o  (tx_tick_o),
  .rx_tick_o  (rx_tick_o),
  .ext_clk_o  (ext_clk_o)
);

// File: tb/sim_baud_clkgen.sv
`timescale 1ns/1ps
module sim_baud_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] div = '0;
  logic        div_wr = 1'b0, sync_m = 1'b0, dbl = 1'b0, pin_out = 1'b0, pol = 1'b0;
  logic        ext_in = 1'b0;
  logic        tx, rx, ext_out;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  bit          ext_run = 1'b0;
  int          ext_half = 3;

  always #10 clk = ~clk;

  baud_clkgen u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .div_wr_i(div_wr),
    .sync_mode_i(sync_m), .dbl_speed_i(dbl), .pin_out_i(pin_out),
    .edge_sel_i(pol), .ext_clk_i(ext_in),
    .tx_tick_o(tx), .rx_tick_o(rx), .ext_clk_o(ext_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tx_period(input bit s, input bit d2, input int d, input int h);
    if (!s) return d2 ? 8 * (d + 1) : 16 * (d + 1);
    if (pin_out) return 2 * (d + 1);
    return 2 * h;
  endfunction

  // free-running external clock for slave scenarios
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        c++;
        if (c >= ext_half) begin ext_in = !ext_in; c = 0; end
      end else c = 0;
    end
  end

  // w: 0 rx tick, 1 tx tick, 2 rising ext_clk_o
  task automatic next_evt(input int w, output int n);
    bit prev = ext_out;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (w == 0 && rx) break;
      if (w == 1 && tx) break;
      if (w == 2 && ext_out && !prev) break;
      prev = ext_out;
      if (n > 20000) break;
    end
  endtask

  task automatic meas(input int w, input int exp, input string req);
    int n;
    next_evt(w, n);
    for (int k = 0; k < 3; k++) begin
      next_evt(w, n);
      check(n == exp, req, n, exp);
    end
  endtask

  task automatic cfg(input bit s, input bit d2, input bit po, input bit pl, input int d);
    @(negedge clk);
    sync_m = s; dbl = d2; pin_out = po; pol = pl;
    div = 12'(d); div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'h1bad5eed);
    int n, d, m, h;
    bit s_dbl, s_pol, bad;
    seed = seed;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!tx && !rx && !ext_out, "R1 reset outputs", {tx, rx, ext_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    meas(0, 1, "R1 divisor zero after reset");

    // random mix of modes
    for (int it = 0; it < 14; it++) begin
      m = int'($urandom % 3);
      d = int'($urandom % 12);
      s_dbl = 1'($urandom);
      s_pol = 1'($urandom);
      if (m == 0) begin
        cfg(1'b0, s_dbl, 1'($urandom), s_pol, d);
        meas(0, d + 1, "R2 rx period");
        meas(1, tx_period(1'b0, s_dbl, d, 0), s_dbl ? "R4 double tx period" : "R3 normal tx period");
        bad = 1'b0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (ext_out) bad = 1'b1; end
        check(!bad, "R9 pin idle async", bad, 0);
      end else if (m == 1) begin
        cfg(1'b1, s_dbl, 1'b1, s_pol, d);
        meas(1, tx_period(1'b1, s_dbl, d, 0), "R6 master tx period");
        meas(0, 2 * (d + 1), "R6 master rx period");
        meas(2, 2 * (d + 1), "R6 master pin period");
        next_evt(1, n);
        check(ext_out == !s_pol, "R7 master tick edge", ext_out, !s_pol);
      end else begin
        h = 3 + int'($urandom % 4);
        cfg(1'b1, s_dbl, 1'b0, s_pol, d);
        ext_half = h; ext_run = 1'b1;
        meas(1, 2 * h, "R8 slave tx period");
        bad = 1'b0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (ext_out) bad = 1'b1; end
        check(!bad, "R9 pin idle slave", bad, 0);
        ext_run = 1'b0;
      end
    end

    // R5: immediate reload, rx timing
    cfg(1'b0, 1'b0, 1'b0, 1'b0, 4095);
    repeat (5) @(negedge clk);
    d = 3;
    div = 12'(d); div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
    check(!rx, "R5 no rx tick after write", rx, 0);
    n = 1;
    while (!rx && n < 100) begin @(negedge clk); n++; end
    check(n == d + 2, "R5 first rx after reload", n, d + 2);

    // R5: tx timing after reload
    cfg(1'b0, 1'b0, 1'b0, 1'b0, 4095);
    d = 2;
    @(negedge clk);
    div = 12'(d); div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
    n = 1;
    while (!tx && n < 1000) begin @(negedge clk); n++; end
    check(n == 16 * (d + 1) + 1, "R5 first tx after reload", n, 16 * (d + 1) + 1);

    // R8: slave latency and polarity
    ext_in = 1'b0;
    cfg(1'b1, 1'b0, 1'b0, 1'b0, 5);
    repeat (5) @(negedge clk);
    ext_in = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check(tx == (k == 3), "R8 rising latency", tx, k == 3);
    end
    repeat (3) @(negedge clk);
    ext_in = 1'b0;
    bad = 1'b0;
    for (int k = 0; k < 4; k++) begin @(negedge clk); if (tx) bad = 1'b1; end
    check(!bad, "R8 falling ignored pol0", bad, 0);
    pol = 1'b1;
    repeat (3) @(negedge clk);
    ext_in = 1'b1;
    bad = 1'b0;
    for (int k = 0; k < 4; k++) begin @(negedge clk); if (tx) bad = 1'b1; end
    check(!bad, "R8 rising ignored pol1", bad, 0);
    ext_in = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check(tx == (k == 3), "R8 falling latency", tx, k == 3);
    end
    check(rx == tx, "R10 sync rx equals tx", rx, tx);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule